// File: doc/BRIEF.md
# Fall-Through Strobe FIFO

This block is a first-in first-out buffer that needs no read request. A word enters when its producer raises a shift-in strobe while the buffer signals room. After a fixed number of clocks the word reaches the output stage on its own, and output-ready rises to show it. The consumer takes the word by raising a shift-out strobe. The model is fully synchronous: both strobes are level signals sampled on the rising clock edge, and each high pulse moves at most one word.

The input side and the output side use the same kind of handshake. One copy's output-ready and data output can therefore feed the next copy's shift-in and data input. The next copy's input-ready comes back as this copy's shift-out. A chain of copies built this way acts as one deeper buffer and needs no extra logic. The depth, the word width (8 or 9 bits in practice) and the fall-through latency are parameters.

Top module: `shift_fifo`

## Requirements
- R1: While rst_n is low, data_out is all zeros, in_ready is 1 and out_ready is 0, and any stored words are discarded. After reset is released, out_ready stays 0 until a new word is written.
- R2: Words leave in the order they were accepted. When a word is accepted into an empty buffer, out_ready rises LATENCY clock edges after the accepting edge (2 by default), with that word on data_out.
- R3: A word is accepted on the first rising clock edge at which all three hold: shift_in is high, shift_in has not already moved a word since it was last low, and in_ready is high. After each accepted word, in_ready is low for exactly one clock when the buffer is not full.
- R4: The buffer holds DEPTH words, counting the word shown on data_out. When DEPTH words are held, in_ready is low and a shift_in pulse is ignored. in_ready is high again in the clock after the edge that removes a word.
- R5: While out_ready stays high, data_out does not change.
- R6: A word is removed on a rising edge at which shift_out is high, shift_out has not already removed a word in the current pulse, and out_ready is high. At that edge out_ready falls and data_out keeps its value. The next word appears no sooner than two edges later, and data_out changes only on the edge at which out_ready rises.
- R7: A shift_out pulse that begins and ends while out_ready is low has no effect. A word that arrives later stays presented.
- R8: When the buffer becomes empty, the last word removed stays on data_out.
- R9: If shift_out is held high while the buffer is empty, a written word falls through and out_ready is high for exactly one clock, after which the word stays on data_out. Words written after it are not presented until shift_out has gone low.
- R10: When a shift_in and a shift_out both take effect on the same edge, the word count does not change and word order is kept.
- R11: Three copies chained output-ready to shift-in, with the downstream in_ready wired back to the upstream shift_out, pass words through in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| shift_in | input | 1 | Write strobe, one word per high pulse |
| data_in | input | WIDTH | Word to write |
| in_ready | output | 1 | Room available and input side idle |
| shift_out | input | 1 | Remove strobe, one word per high pulse |
| out_ready | output | 1 | A valid, stable word is on data_out |
| data_out | output | WIDTH | Presented word |

## Verification
A wrong occupancy count shows up at the full boundary. in_ready either drops before DEPTH words are held, or it lets one more word in, and that extra word surfaces as an unexpected item when the buffer is drained. A broken arrival counter or strobe state shows within a few clocks of a write or a removal. Either out_ready comes up at the wrong edge after the LATENCY count, a held shift_out removes more than one word, or data_out moves while out_ready is high. A pointer error shows as a word out of order at the very next removal.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;

  // State of one strobe: armed until its high pulse has moved a word.
  typedef enum logic {
    STROBE_ARMED = 1'b0,
    STROBE_SPENT = 1'b1
  } strobe_e;

endpackage

// File: rtl/sf_strobe.sv
// Tracks whether the current high pulse of a strobe has already acted.
module sf_strobe
  import shift_fifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic fire,
  output logic spent
);

  strobe_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!strobe)   st_d = STROBE_ARMED;
    else if (fire) st_d = STROBE_SPENT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= STROBE_ARMED;
    else        st_q <= st_d;
  end

  assign spent = (st_q == STROBE_SPENT);

endmodule

// File: rtl/sf_store.sv
// Circular word storage; read data is the oldest stored word.
module sf_store #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data
);

  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (wr_en) wr_ptr_d = wr_ptr_q + AW'(1);
    if (rd_en) rd_ptr_d = rd_ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_data;
  end

  assign rd_data = mem[rd_ptr_q];

endmodule

// File: rtl/sf_arrival.sv
// Delays each accepted word by the fall-through time and counts the
// stored words that have completed it. LATENCY must be at least 2.
module sf_arrival #(
  parameter int DEPTH   = 64,
  parameter int LATENCY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic take,
  output logic word_ready
);

  localparam int CW = $clog2(DEPTH) + 1;

  logic          landed;
  logic [CW-1:0] cnt_q, cnt_d;

  if (LATENCY == 2) begin : g_short
    logic stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= 1'b0;
      else        stage_q <= push;
    end
    assign landed = stage_q;
  end else begin : g_long
    logic [LATENCY-2:0] stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[LATENCY-3:0], push};
    end
    assign landed = stage_q[LATENCY-2];
  end

  always_comb begin
    cnt_d = cnt_q + CW'(landed) - CW'(take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (landed || take) cnt_q <= cnt_d;
  end

  assign word_ready = (cnt_q != '0);

endmodule

// File: rtl/shift_fifo.sv
module shift_fifo #(
  parameter int WIDTH   = 9,
  parameter int DEPTH   = 64,
  parameter int LATENCY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] data_in,
  output logic             in_ready,
  input  logic             shift_out,
  output logic             out_ready,
  output logic [WIDTH-1:0] data_out
);

  localparam int CW = $clog2(DEPTH) + 1;

  logic             accept, remove, load;
  logic             si_spent, so_spent;
  logic             word_ready;
  logic [WIDTH-1:0] head_word;

  logic [CW-1:0]    occ_q, occ_d;
  logic             busy_q;
  logic             show_q, show_d;
  logic [WIDTH-1:0] dout_q;

  assign in_ready = (occ_q != CW'(DEPTH)) && !busy_q;

  assign accept = shift_in  && !si_spent && in_ready;
  assign remove = shift_out && !so_spent && show_q;
  assign load   = !show_q && word_ready && !so_spent;

  sf_strobe u_in_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (shift_in),
    .fire   (accept),
    .spent  (si_spent)
  );

  sf_strobe u_out_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (shift_out),
    .fire   (remove),
    .spent  (so_spent)
  );

  sf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_data (data_in),
    .rd_en   (load),
    .rd_data (head_word)
  );

  sf_arrival #(.DEPTH(DEPTH), .LATENCY(LATENCY)) u_arrival (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (accept),
    .take       (load),
    .word_ready (word_ready)
  );

  always_comb begin
    occ_d  = occ_q + CW'(accept) - CW'(remove);
    show_d = show_q;
    if (load)        show_d = 1'b1;
    else if (remove) show_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      busy_q <= 1'b0;
      show_q <= 1'b0;
      dout_q <= '0;
    end else begin
      busy_q <= accept;
      show_q <= show_d;
      if (accept != remove) occ_q  <= occ_d;
      if (load)             dout_q <= head_word;
    end
  end

  assign out_ready = show_q;
  assign data_out  = dout_q;

endmodule

// File: rtl/shift_fifo_chk.sv
module shift_fifo_chk #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       shift_out,
  input logic                       in_ready,
  input logic                       out_ready,
  input logic [WIDTH-1:0]           data_out,
  input logic [$clog2(DEPTH):0]     occ
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (in_ready && !out_ready && data_out == '0)
        else $error("reset state wrong");
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= ($clog2(DEPTH) + 1)'(DEPTH));

  assert_hold_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready && $past(out_ready) |-> $stable(data_out));

  assert_change_on_show_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_out) |-> $rose(out_ready));

  assert_remove_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_ready) |-> $past(shift_out));

  assert_show_needs_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_ready) |-> occ != '0);

endmodule

bind shift_fifo shift_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .shift_out (shift_out),
  .in_ready  (in_ready),
  .out_ready (out_ready),
  .data_out  (data_out),
  .occ       (occ_q)
);

// File: tb/shift_fifo_tb_top.sv
module shift_fifo_tb_top;

  localparam int W   = 9;
  localparam int D   = 64;
  localparam int LAT = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n;
  logic         si = 1'b0;
  logic [W-1:0] din = '0;
  logic         man_so = 1'b0, mon_so = 1'b0, mon_en = 1'b0;
  logic         so;
  logic         in_ready, out_ready;
  logic [W-1:0] dout;

  assign so = mon_en ? mon_so : man_so;

  shift_fifo #(.WIDTH(W), .DEPTH(D), .LATENCY(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .shift_in(si), .data_in(din), .in_ready(in_ready),
    .shift_out(so), .out_ready(out_ready), .data_out(dout)
  );

  // three-copy chain
  logic         c_si = 1'b0, c_so = 1'b0;
  logic [W-1:0] c_din = '0;
  logic         c0_ir, c1_ir, c2_ir, c0_or, c1_or, c2_or;
  logic [W-1:0] c0_do, c1_do, c2_do;

  shift_fifo #(.WIDTH(W), .DEPTH(D), .LATENCY(LAT)) u_c0 (
    .clk(clk), .rst_n(rst_n), .shift_in(c_si), .data_in(c_din), .in_ready(c0_ir),
    .shift_out(c1_ir), .out_ready(c0_or), .data_out(c0_do));
  shift_fifo #(.WIDTH(W), .DEPTH(D), .LATENCY(LAT)) u_c1 (
    .clk(clk), .rst_n(rst_n), .shift_in(c0_or), .data_in(c0_do), .in_ready(c1_ir),
    .shift_out(c2_ir), .out_ready(c1_or), .data_out(c1_do));
  shift_fifo #(.WIDTH(W), .DEPTH(D), .LATENCY(LAT)) u_c2 (
    .clk(clk), .rst_n(rst_n), .shift_in(c1_or), .data_in(c1_do), .in_ready(c2_ir),
    .shift_out(c_so), .out_ready(c2_or), .data_out(c2_do));

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] exp_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // driver: writes one word and records it as expected
  task automatic push(input logic [W-1:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    din = w;
    si  = 1'b1;
    @(negedge clk);
    si  = 1'b0;
    exp_q.push_back(w);
  endtask

  task automatic drain();
    mon_en = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    mon_en = 1'b0;
    check(!out_ready, "R4 no extra word after drain", int'(out_ready), 0);
  endtask

  // monitor: removes presented words and compares them with the scoreboard
  always @(negedge clk) begin : monitor
    logic [W-1:0] w;
    if (mon_en && out_ready && !mon_so) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected word", int'(dout), 0);
      end else begin
        w = exp_q.pop_front();
        check(dout == w, "R2 order", int'(dout), int'(w));
      end
      mon_so = 1'b1;
    end else begin
      mon_so = 1'b0;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin : main
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(dout == '0, "R1 reset data", int'(dout), 0);
    check(in_ready, "R1 reset in_ready", int'(in_ready), 1);
    check(!out_ready, "R1 reset out_ready", int'(out_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!out_ready, "R1 idle after release", int'(out_ready), 0);

    // latency on an empty buffer
    din = 9'h1A5; si = 1'b1;
    @(negedge clk); si = 1'b0;
    check(!in_ready, "R3 busy after accept", int'(in_ready), 0);
    check(!out_ready, "R2 not yet shown", int'(out_ready), 0);
    for (int k = 1; k < LAT; k++) begin
      @(negedge clk);
      if (k < LAT - 1) check(!out_ready, "R2 early show", int'(out_ready), 0);
    end
    check(!out_ready || LAT > 2, "R2 early show", int'(out_ready), 0);
    @(negedge clk);
    check(out_ready, "R2 latency", int'(out_ready), 1);
    check(dout == 9'h1A5, "R2 data", int'(dout), 'h1A5);
    check(in_ready, "R3 busy one clock", int'(in_ready), 1);
    repeat (4) begin
      @(negedge clk);
      check(out_ready && dout == 9'h1A5, "R5 stable", int'(dout), 'h1A5);
    end

    // removal, then empty hold
    man_so = 1'b1;
    @(negedge clk); man_so = 1'b0;
    check(!out_ready, "R6 ready falls", int'(out_ready), 0);
    check(dout == 9'h1A5, "R6 data kept", int'(dout), 'h1A5);
    repeat (5) @(negedge clk);
    check(!out_ready && dout == 9'h1A5, "R8 last word kept", int'(dout), 'h1A5);

    // shift_out pulse on an empty buffer has no effect
    man_so = 1'b1;
    @(negedge clk); man_so = 1'b0;
    push(9'h0C3);
    repeat (LAT + 3) @(negedge clk);
    check(out_ready && dout == 9'h0C3, "R7 word not consumed", int'(dout), 'h0C3);
    drain();

    // held shift_out: fall through, one clock of ready
    man_so = 1'b1;
    @(negedge clk);
    din = 9'h111; si = 1'b1;
    @(negedge clk); si = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    @(negedge clk);
    check(out_ready && dout == 9'h111, "R9 word shown", int'(dout), 'h111);
    @(negedge clk);
    check(!out_ready && dout == 9'h111, "R9 one clock only", int'(out_ready), 0);
    push(9'h122);
    push(9'h133);
    repeat (6) begin
      @(negedge clk);
      check(!out_ready && dout == 9'h111, "R9 later words wait", int'(dout), 'h111);
    end
    man_so = 1'b0;
    drain();

    // fill to capacity
    for (int i = 0; i < D; i++) push(W'(i * 7 + 3));
    repeat (3) @(negedge clk);
    check(!in_ready, "R4 full", int'(in_ready), 0);
    din = 9'h1FF; si = 1'b1;
    @(negedge clk); si = 1'b0;
    repeat (2) @(negedge clk);
    check(!in_ready, "R4 still full", int'(in_ready), 0);
    check(out_ready && dout == exp_q[0], "R4 head word", int'(dout), int'(exp_q[0]));
    man_so = 1'b1;
    @(negedge clk); man_so = 1'b0;
    void'(exp_q.pop_front());
    check(in_ready, "R4 room after removal", int'(in_ready), 1);
    drain();

    // simultaneous write and removal
    push(9'h0A1); push(9'h0A2); push(9'h0A3);
    @(negedge clk);
    while (!(in_ready && out_ready)) @(negedge clk);
    check(dout == 9'h0A1, "R10 head", int'(dout), 'h0A1);
    din = 9'h0A4; si = 1'b1; man_so = 1'b1;
    @(negedge clk); si = 1'b0; man_so = 1'b0;
    void'(exp_q.pop_front());
    exp_q.push_back(9'h0A4);
    check(!out_ready && !in_ready, "R10 both acted", int'({in_ready, out_ready}), 0);
    drain();

    // master reset with words stored
    push(9'h055); push(9'h066);
    exp_q.delete();
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(dout == '0 && !out_ready && in_ready, "R1 reset clears", int'(dout), 0);
    rst_n = 1'b1;
    repeat (LAT + 3) @(negedge clk);
    check(!out_ready, "R1 buffer emptied", int'(out_ready), 0);

    // three-copy chain keeps order
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      while (!c0_ir) @(negedge clk);
      c_din = W'(9'h100 + i * 5); c_si = 1'b1;
      @(negedge clk); c_si = 1'b0;
    end
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      while (!c2_or) @(negedge clk);
      check(c2_do == W'(9'h100 + i * 5), "R11 chain order", int'(c2_do), 'h100 + i * 5);
      c_so = 1'b1;
      @(negedge clk); c_so = 1'b0;
    end
    repeat (10) @(negedge clk);
    check(!c2_or, "R11 no extra word", int'(c2_or), 0);

    finish_run();
  end

endmodule